// File: doc/BRIEF.md
# Audio Transmit Sample Buffer with Burst Request

This block holds outgoing audio samples between the register-side write port and the serial audio shifter. Each accepted bus write places one 32-bit word into a circular store of `DEPTH` entries. The serializer takes one word per channel slot through a valid/ready port. Words leave in the order they arrived. A one-bit packing mode is applied when a word is written. In mode 0 the word is stored unchanged. In mode 1 a 16-bit sample that arrives in the low half of the bus word is moved to the upper half of the stored word.

Back-pressure rules:
- On the write side, `wr_ready` is low while the store is full or a flush is in progress. The write source is a bus that cannot wait. A write offered while `wr_ready` is low is therefore discarded. If the store was full, the write also sets a sticky overflow flag.
- On the read side, `ser_valid` is high whenever a word can be taken. A slot request (`ser_ready`) made while nothing is valid removes nothing and presents zero on `ser_data`.

Software control is through plain pins:
- `flush_cmd` starts a flush. The flush executes one cycle later and then clears itself.
- `drq_en` gates a DMA request. The request is raised only when a full burst of `BURST` words fits in the free space.
- `sent_count` counts the words handed to the serializer. `cnt_clr` sets it back to zero.

Top module: `pcm_tx_buffer`

## Requirements
- R1: After reset, `fill_level` is 0, `free_slots` is `DEPTH` (64), and `ser_valid`, `ser_data`, `overflow`, `flush_busy`, `drq` and `sent_count` are all zero.
- R2: A word is accepted on a rising edge where `wr_valid` and `wr_ready` are both high. It is consumed on a rising edge where `ser_valid` and `ser_ready` are both high. Consumed words appear on `ser_data` in exactly the order they were accepted, including when writes and reads happen in the same cycles.
- R3: The `pack_mode` value sampled with each accepted write decides how that word is stored. With mode 0 the stored word equals `wr_data`. With mode 1 the stored word is `{wr_data[15:0], 16'h0000}`.
- R4: When `fill_level` equals `DEPTH`, `wr_ready` is low. A write offered in that state is dropped and `fill_level` stays at `DEPTH`. The write also sets `overflow`, which then stays high until a flush executes.
- R5: While the store is empty, `ser_valid` is low and `ser_data` is zero. A `ser_ready` in that state changes neither `fill_level` nor `sent_count`.
- R6: A `flush_cmd` pulse sets `flush_busy` high at the next edge. At the edge after that, `flush_busy` returns low on its own, `fill_level` becomes 0 and `overflow` is cleared. While `flush_busy` is high, `wr_ready` and `ser_valid` are low.
- R7: `drq` is high exactly when `drq_en` is high and `free_slots` is at least `BURST` (4). With `drq_en` low, `drq` is always low.
- R8: `sent_count` increases by one at every edge that consumes a word, and holds its value otherwise.
- R9: An edge with `cnt_clr` high sets `sent_count` to 0. If that same edge also consumes a word, `sent_count` becomes 1.
- R10: `fill_level + free_slots` always equals `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Bus write of a sample word |
| wr_ready | output | 1 | Space available and no flush in progress |
| wr_data | input | DATA_W (32) | Written sample word |
| pack_mode | input | 1 | 0: store the word as is; 1: move the low half to the upper half |
| ser_valid | output | 1 | A word is available to the serializer |
| ser_ready | input | 1 | Serializer takes a word this cycle |
| ser_data | output | DATA_W (32) | Head word, zero when nothing is valid |
| flush_cmd | input | 1 | Request to empty the store |
| flush_busy | output | 1 | Flush executing this cycle (self-clearing) |
| drq_en | input | 1 | DMA request enable |
| drq | output | 1 | DMA request: room for one full burst |
| cnt_clr | input | 1 | Clear the sent-word counter |
| sent_count | output | CNT_W (32) | Words handed to the serializer |
| fill_level | output | $clog2(DEPTH)+1 | Occupied entries |
| free_slots | output | $clog2(DEPTH)+1 | Free entries |
| overflow | output | 1 | Sticky flag: a write hit a full store |

## Verification
The hardest states to reach from the ports are the two ends of the free-space range.

The overflow path needs the store completely full, with one more write offered. To get there, the bench writes `DEPTH` words while the serializer side is idle, then offers one extra word. Because that word is dropped, it must never reach the scoreboard.

The request threshold needs the free count to sit exactly on 3 and then on 4. The bench reaches both values by draining that full store one word at a time.

Each of these edges is checked at its exact cycle:
- the flush executing while the flag is still set;
- the counter clear coinciding with a consumed word.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  typedef enum logic {
    PACK_AS_IS    = 1'b0,
    PACK_LOW_HALF = 1'b1
  } pack_mode_e;

  localparam int DEFAULT_DEPTH = 64;
  localparam int DEFAULT_BURST = 4;
endpackage

// File: rtl/txbuf_ring.sv
module txbuf_ring #(
  parameter int DEPTH = 64,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     push,
  input  logic [W-1:0]             push_data,
  input  logic                     pop,
  output logic [W-1:0]             head_data,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];
  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
endmodule

// File: rtl/txbuf_drq.sv
module txbuf_drq #(
  parameter int DEPTH = 64,
  parameter int BURST = 4
) (
  input  logic                   enable,
  input  logic [$clog2(DEPTH):0] free,
  output logic                   request
);
  localparam int LW = $clog2(DEPTH) + 1;
  assign request = enable && (free >= LW'(BURST));
endmodule

// File: rtl/txbuf_sent_cnt.sv
module txbuf_sent_cnt #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= CW'(inc);
    else if (inc) count <= count + CW'(1);
  end
endmodule

// File: rtl/pcm_tx_buffer.sv
module pcm_tx_buffer #(
  parameter int DEPTH  = txbuf_pkg::DEFAULT_DEPTH,
  parameter int DATA_W = 32,
  parameter int BURST  = txbuf_pkg::DEFAULT_BURST,
  parameter int CNT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   pack_mode,
  output logic                   ser_valid,
  input  logic                   ser_ready,
  output logic [DATA_W-1:0]      ser_data,
  input  logic                   flush_cmd,
  output logic                   flush_busy,
  input  logic                   drq_en,
  output logic                   drq,
  input  logic                   cnt_clr,
  output logic [CNT_W-1:0]       sent_count,
  output logic [$clog2(DEPTH):0] fill_level,
  output logic [$clog2(DEPTH):0] free_slots,
  output logic                   overflow
);
  import txbuf_pkg::*;

  localparam int LW   = $clog2(DEPTH) + 1;
  localparam int HALF = DATA_W / 2;

  logic              full, empty, push_ok, pop_ok;
  logic [DATA_W-1:0] packed_word, head_word;
  pack_mode_e        mode;

  assign mode = pack_mode_e'(pack_mode);

  always_comb begin
    if (mode == PACK_LOW_HALF) packed_word = {wr_data[HALF-1:0], {HALF{1'b0}}};
    else                       packed_word = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_busy <= 1'b0;
    else        flush_busy <= flush_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          overflow <= 1'b0;
    else if (flush_busy)                 overflow <= 1'b0;
    else if (wr_valid && full)           overflow <= 1'b1;
  end

  assign wr_ready  = !full && !flush_busy;
  assign push_ok   = wr_valid && wr_ready;
  assign ser_valid = !empty && !flush_busy;
  assign pop_ok    = ser_valid && ser_ready;
  assign ser_data  = ser_valid ? head_word : '0;

  txbuf_ring #(.DEPTH(DEPTH), .W(DATA_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush_busy),
    .push      (push_ok),
    .push_data (packed_word),
    .pop       (pop_ok),
    .head_data (head_word),
    .level     (fill_level),
    .full      (full),
    .empty     (empty)
  );

  assign free_slots = LW'(DEPTH) - fill_level;

  txbuf_drq #(.DEPTH(DEPTH), .BURST(BURST)) u_drq (
    .enable  (drq_en),
    .free    (free_slots),
    .request (drq)
  );

  txbuf_sent_cnt #(.CW(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (pop_ok),
    .count (sent_count)
  );
endmodule

// File: rtl/txbuf_checker.sv
module txbuf_checker #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int BURST  = 4,
  parameter int CNT_W  = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_ready,
  input logic                   ser_valid,
  input logic                   ser_ready,
  input logic [DATA_W-1:0]      ser_data,
  input logic                   flush_cmd,
  input logic                   flush_busy,
  input logic                   drq_en,
  input logic                   drq,
  input logic                   cnt_clr,
  input logic [CNT_W-1:0]       sent_count,
  input logic [$clog2(DEPTH):0] fill_level,
  input logic [$clog2(DEPTH):0] free_slots,
  input logic                   overflow
);
  localparam int LW = $clog2(DEPTH) + 1;

  p_level_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fill_level} + {1'b0, free_slots}) == (LW+1)'(DEPTH));

  p_full_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == LW'(DEPTH)) |-> !wr_ready);

  p_overflow_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush_busy) |=> overflow);

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> (ser_data == '0));

  p_flush_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_busy && !flush_cmd) |=> !flush_busy);

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (fill_level == '0 && !overflow));

  p_drq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !drq_en |-> !drq);

  p_drq_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> (free_slots >= LW'(BURST)));

  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !(ser_valid && ser_ready)) |=> $stable(sent_count));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && ser_valid && ser_ready) |=> (sent_count == $past(sent_count) + CNT_W'(1)));

  p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (sent_count <= CNT_W'(1)));
endmodule

bind pcm_tx_buffer txbuf_checker #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .BURST(BURST), .CNT_W(CNT_W)
) u_txbuf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ready   (wr_ready),
  .ser_valid  (ser_valid),
  .ser_ready  (ser_ready),
  .ser_data   (ser_data),
  .flush_cmd  (flush_cmd),
  .flush_busy (flush_busy),
  .drq_en     (drq_en),
  .drq        (drq),
  .cnt_clr    (cnt_clr),
  .sent_count (sent_count),
  .fill_level (fill_level),
  .free_slots (free_slots),
  .overflow   (overflow)
);

// File: tb/test_pcm_tx_buffer.sv
`timescale 1ns/1ps
module test_pcm_tx_buffer;
  localparam int DEPTH = 64;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, pack_mode = 1'b0, ser_ready = 1'b0;
  logic        flush_cmd = 1'b0, drq_en = 1'b0, cnt_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, ser_valid, flush_busy, drq, overflow;
  logic [31:0] ser_data, sent_count;
  logic [LW-1:0] fill_level, free_slots;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int model_level = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  pcm_tx_buffer i_pcm_tx_buffer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .pack_mode(pack_mode), .ser_valid(ser_valid),
    .ser_ready(ser_ready), .ser_data(ser_data), .flush_cmd(flush_cmd),
    .flush_busy(flush_busy), .drq_en(drq_en), .drq(drq), .cnt_clr(cnt_clr),
    .sent_count(sent_count), .fill_level(fill_level), .free_slots(free_slots),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares every consumed word with the queue head.
  always @(negedge clk) begin
    if (rst_n && ser_valid && ser_ready) begin
      logic [31:0] e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected word", ser_data, 0);
      end else begin
        e = exp_q.pop_front();
        check(ser_data == e, "R2/R3 order and packing", ser_data, e);
      end
    end
  end

  task automatic push(input logic [31:0] d, input logic m);
    wr_valid = 1'b1; wr_data = d; pack_mode = m;
    if (model_level < DEPTH) begin
      exp_q.push_back(m ? {d[15:0], 16'h0000} : d);
      model_level++;
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    ser_ready = 1'b1;
    repeat (n) begin @(posedge clk); #1; end
    ser_ready = 1'b0;
    model_level -= n;
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fill_level == 0, "R1 level", fill_level, 0);
    check(free_slots == DEPTH, "R1 free", free_slots, DEPTH);
    check(!ser_valid && ser_data == 0, "R1 ser", ser_data, 0);
    check(!overflow && !flush_busy, "R1 flags", {overflow, flush_busy}, 0);
    check(sent_count == 0 && !drq, "R1 count/drq", sent_count, 0);
    // R7 gate
    drq_en = 1'b1;
    #1 check(drq == 1'b1, "R7 drq enabled with room", drq, 1);
    @(posedge clk); #1;

    // R2 mode 0 words
    for (int i = 0; i < 5; i++) push(32'hA000_0000 + 32'(i * 17), 1'b0);
    @(negedge clk);
    check(fill_level == 5, "R2 level after writes", fill_level, 5);
    check(free_slots == DEPTH - 5, "R10 free", free_slots, DEPTH - 5);
    @(posedge clk); #1;
    drain(5);
    @(negedge clk);
    check(sent_count == 5, "R8 count", sent_count, 5);

    // R3 mode 1 packing
    push(32'h1234_BEEF, 1'b1);
    push(32'hFFFF_0001, 1'b1);
    push(32'h0000_8000, 1'b1);
    drain(3);
    @(negedge clk);
    check(sent_count == 8, "R8 count after packed", sent_count, 8);

    // R5 reading an empty store
    @(posedge clk); #1;
    ser_ready = 1'b1;
    @(negedge clk);
    check(!ser_valid && ser_data == 0, "R5 empty head", ser_data, 0);
    @(posedge clk); #1;
    ser_ready = 1'b0;
    @(negedge clk);
    check(sent_count == 8 && fill_level == 0, "R5 no effect", sent_count, 8);

    // R4 fill to full, then one extra write
    @(posedge clk); #1;
    for (int i = 0; i < DEPTH; i++) push(32'h5500_0000 + 32'(i), 1'b0);
    @(negedge clk);
    check(fill_level == DEPTH && !wr_ready, "R4 full", fill_level, DEPTH);
    check(drq == 1'b0, "R7 no room", drq, 0);
    @(posedge clk); #1;
    push(32'hDEAD_DEAD, 1'b0);
    @(negedge clk);
    check(overflow == 1'b1, "R4 overflow set", overflow, 1);
    check(fill_level == DEPTH, "R4 level held", fill_level, DEPTH);
    @(posedge clk); #1;
    drain(3);
    @(negedge clk);
    check(free_slots == 3 && drq == 1'b0, "R7 free 3", drq, 0);
    @(posedge clk); #1;
    drain(1);
    @(negedge clk);
    check(free_slots == 4 && drq == 1'b1, "R7 free 4", drq, 1);
    check(overflow == 1'b1, "R4 overflow sticky", overflow, 1);
    check(sent_count == 12, "R8 count", sent_count, 12);

    // R6 flush
    @(posedge clk); #1;
    flush_cmd = 1'b1;
    @(posedge clk); #1;
    flush_cmd = 1'b0;
    @(negedge clk);
    check(flush_busy && !wr_ready && !ser_valid, "R6 busy", flush_busy, 1);
    @(posedge clk); #1;
    exp_q.delete();
    model_level = 0;
    @(negedge clk);
    check(!flush_busy, "R6 self-clear", flush_busy, 0);
    check(fill_level == 0 && free_slots == DEPTH, "R6 emptied", fill_level, 0);
    check(!overflow, "R6 overflow cleared", overflow, 0);

    // R9 counter clear
    @(posedge clk); #1;
    cnt_clr = 1'b1;
    @(posedge clk); #1;
    cnt_clr = 1'b0;
    @(negedge clk);
    check(sent_count == 0, "R9 clear", sent_count, 0);
    @(posedge clk); #1;
    push(32'h0BAD_CAFE, 1'b0);
    cnt_clr = 1'b1;
    drain(1);
    cnt_clr = 1'b0;
    @(negedge clk);
    check(sent_count == 1, "R9 clear with pop", sent_count, 1);

    // R2 concurrent streaming
    @(posedge clk); #1;
    ser_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      wr_valid = 1'b1; wr_data = 32'hC0DE_0000 + 32'(i); pack_mode = 1'b0;
      exp_q.push_back(wr_data);
      @(posedge clk); #1;
    end
    wr_valid = 1'b0;
    @(posedge clk); #1;
    ser_ready = 1'b0;
    model_level = 0;
    @(negedge clk);
    check(sent_count == 21, "R8 streaming count", sent_count, 21);
    check(exp_q.size() == 0, "R2 all words seen", exp_q.size(), 0);
    check(fill_level == 0, "R10 level after stream", fill_level, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule